// File: doc/BRIEF.md
# Variable-Rate SPI Bus Clock Generator

This block produces the serial bus clock for an SPI master, and its rate can change from one half-period to the next inside a single word. Two 16-bit divider values are offered. A 32-bit pattern chooses between them for each half-period of the bus clock. The pattern is read from its top bit down to bit 0, and each bit covers one half-period. A 16-bit word therefore uses all 32 pattern bits. The block has two other modes. In the fixed mode only the first divider is used. In the bypass mode the bus clock toggles on every system clock.

A start pulse begins a word of 32 half-periods. The block raises a one-cycle strobe on every rising edge and on every falling edge of the bus clock, so a separate shifter can launch and capture data. It gives a done pulse together with the final edge. Between words the bus clock rests at the idle level chosen by the polarity input. Data shifting is done by another block. The divider, pattern and mode inputs are expected to stay stable while a word is running.

Top module: `spi_varclk_gen`

## Requirements
- R1: After reset, and whenever no word is running, `sclk` equals `cpol`, `busy` is 0, and `riseStb`, `fallStb` and `doneP` are 0.
- R2: When `startP` is sampled high while idle, `busy` is 1 from the next cycle. The first bus clock edge then follows one half-period later.
- R3: In variable mode (`varEn`=1), half-period k (k = 0..31) uses pattern bit 31-k. It lasts `divB`+1 system clocks when that bit is 1 and `divA`+1 system clocks when that bit is 0.
- R4: In fixed mode (`varEn`=0, bypass not in effect), every half-period lasts `divA`+1 system clocks. `divB` and `pattern` have no effect on the edge timing.
- R5: Bypass takes effect only when `bypassEn`=1 while `varEn`=0 and `reorderEn`=0. In that case every half-period lasts exactly one system clock, whatever the divider values are.
- R6: When `bypassEn`=1 but `varEn` or `reorderEn` is 1, bypass is ignored and the timing follows R3 or R4.
- R7: A word has exactly 32 bus clock edges. `doneP` is high for one cycle, in the same cycle as the final edge. In that cycle `busy` returns to 0 and `sclk` is back at its idle level.
- R8: `riseStb` is high for the one cycle in which `sclk` has just changed from 0 to 1. `fallStb` is high for the one cycle in which `sclk` has just changed from 1 to 0. The two strobes are never high together.
- R9: A `startP` pulse while `busy` is 1 is ignored. This includes a pulse in the cycle that produces the final edge. The word's edge timing does not change, and no new word starts.
- R10: Every word starts again from pattern bit 31, whatever the previous word did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startP | input | 1 | One-cycle request to begin a word |
| cpol | input | 1 | Idle level of the bus clock |
| varEn | input | 1 | Selects variable mode: divider per half-period taken from `pattern` |
| bypassEn | input | 1 | Requests one system clock per half-period |
| reorderEn | input | 1 | Byte reorder active elsewhere; when 1, bypass is blocked |
| divA | input | 16 | First divider; half-period = divA+1 clocks |
| divB | input | 16 | Second divider; used only in variable mode |
| pattern | input | 32 | Per-half-period divider choice; bit 31 is used first |
| sclk | output | 1 | SPI bus clock |
| riseStb | output | 1 | `sclk` has just risen |
| fallStb | output | 1 | `sclk` has just fallen |
| busy | output | 1 | A word is in progress |
| doneP | output | 1 | One-cycle pulse with the final edge of a word |

## Verification
Two events can fall in the same cycle: the final half-period ends and a new start request arrives. The start request is ignored while `busy` is still high in that cycle. The bench provokes this by driving `startP` in the cycle whose clock edge produces the 32nd bus clock edge. It then checks that `doneP` appears with that edge, that `busy` is 0 one cycle later, and that `sclk` stays at its idle level. A start pulse in the middle of a word is also checked: every remaining half-period length must be unchanged.

// File: rtl/varclk_pkg.sv
`timescale 1ns/1ps
package varclk_pkg;
  // Strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic busy;  // a word is in progress
    logic load;  // begin a word this cycle
    logic step;  // current half-period ends this cycle
  } clk_ctl_t;
endpackage

// File: rtl/varclk_ctrl.sv
`timescale 1ns/1ps
module varclk_ctrl
  import varclk_pkg::*;
#(
  parameter int PAT_W = 32,
  parameter int IDX_W = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startP,
  input  logic             halfEnd,
  output clk_ctl_t         ctl,
  output logic [IDX_W-1:0] patIdx,
  output logic             busy,
  output logic             doneP
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(PAT_W - 1);

  logic             busyQ;
  logic [IDX_W-1:0] idxQ;
  logic             doneQ;
  logic             loadNow;
  logic             stepNow;
  logic             lastStep;

  always_comb begin
    loadNow  = !busyQ && startP;
    stepNow  = busyQ && halfEnd;
    lastStep = stepNow && (idxQ == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= lastStep;
      if (loadNow) begin
        busyQ <= 1'b1;
        idxQ  <= TOP_IDX;
      end else if (stepNow) begin
        idxQ <= idxQ - 1'b1;
        if (lastStep) busyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.busy = busyQ;
    ctl.load = loadNow;
    ctl.step = stepNow;
    patIdx   = idxQ;
    busy     = busyQ;
    doneP    = doneQ;
  end

  // R7
  done_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (!busyQ && $past(busyQ)));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && startP && !halfEnd) |=> (idxQ == $past(idxQ)));

  // R2 R10
  start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && startP) |=> (busyQ && idxQ == TOP_IDX));
endmodule

// File: rtl/varclk_dp.sv
`timescale 1ns/1ps
module varclk_dp
  import varclk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int PAT_W = 32,
  parameter int IDX_W = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  clk_ctl_t         ctl,
  input  logic [IDX_W-1:0] patIdx,
  input  logic             cpol,
  input  logic             varEn,
  input  logic             bypassEn,
  input  logic             reorderEn,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divB,
  input  logic [PAT_W-1:0] pattern,
  output logic             halfEnd,
  output logic             sclk,
  output logic             riseStb,
  output logic             fallStb
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] curDiv;
  logic             phase;
  logic             riseQ;
  logic             fallQ;
  logic             bypassOn;

  // Divider chosen for the present half-period
  always_comb begin
    bypassOn = bypassEn && !varEn && !reorderEn;
    if (bypassOn)                     curDiv = '0;
    else if (varEn && pattern[patIdx]) curDiv = divB;
    else                              curDiv = divA;
    halfEnd = ctl.busy && (cnt == curDiv);
    sclk    = phase ^ cpol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= 1'b0;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      riseQ <= ctl.step && !sclk;
      fallQ <= ctl.step && sclk;
      if (ctl.load) begin
        cnt   <= '0;
        phase <= 1'b0;
      end else if (ctl.step) begin
        cnt   <= '0;
        phase <= ~phase;
      end else if (ctl.busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    riseStb = riseQ;
    fallStb = fallQ;
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({riseQ, fallQ}));

  // R8
  rise_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseQ |-> sclk);

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.busy |-> (sclk == cpol));

  // R3 R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |-> (cnt <= curDiv));
endmodule

// File: rtl/spi_varclk_gen.sv
`timescale 1ns/1ps
module spi_varclk_gen
  import varclk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int PAT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startP,
  input  logic             cpol,
  input  logic             varEn,
  input  logic             bypassEn,
  input  logic             reorderEn,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divB,
  input  logic [PAT_W-1:0] pattern,
  output logic             sclk,
  output logic             riseStb,
  output logic             fallStb,
  output logic             busy,
  output logic             doneP
);
  localparam int IDX_W = $clog2(PAT_W);

  clk_ctl_t         ctl;
  logic [IDX_W-1:0] patIdx;
  logic             halfEnd;

  varclk_ctrl #(.PAT_W(PAT_W), .IDX_W(IDX_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startP  (startP),
    .halfEnd (halfEnd),
    .ctl     (ctl),
    .patIdx  (patIdx),
    .busy    (busy),
    .doneP   (doneP)
  );

  varclk_dp #(.DIV_W(DIV_W), .PAT_W(PAT_W), .IDX_W(IDX_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .patIdx    (patIdx),
    .cpol      (cpol),
    .varEn     (varEn),
    .bypassEn  (bypassEn),
    .reorderEn (reorderEn),
    .divA      (divA),
    .divB      (divB),
    .pattern   (pattern),
    .halfEnd   (halfEnd),
    .sclk      (sclk),
    .riseStb   (riseStb),
    .fallStb   (fallStb)
  );
endmodule

// File: tb/sim_spi_varclk_gen.sv
`timescale 1ns/1ps
module sim_spi_varclk_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        startP = 1'b0;
  logic        cpol = 1'b0;
  logic        varEn = 1'b0;
  logic        bypassEn = 1'b0;
  logic        reorderEn = 1'b0;
  logic [15:0] divA = 16'd0;
  logic [15:0] divB = 16'd0;
  logic [31:0] pattern = 32'd0;
  logic        sclk, riseStb, fallStb, busy, doneP;

  int total = 0;
  int bad = 0;

  spi_varclk_gen u0 (
    .clk(clk), .rstN(rstN), .startP(startP), .cpol(cpol), .varEn(varEn),
    .bypassEn(bypassEn), .reorderEn(reorderEn), .divA(divA), .divB(divB),
    .pattern(pattern), .sclk(sclk), .riseStb(riseStb), .fallStb(fallStb),
    .busy(busy), .doneP(doneP)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected half-period length from the requirements
  function automatic int expLen(input int k);
    if (bypassEn && !varEn && !reorderEn) return 1;
    if (varEn && pattern[31-k]) return int'(divB) + 1;
    return int'(divA) + 1;
  endfunction

  // Runs one word, checks every edge; injectAt>0 drives startP in that cycle
  task automatic runXfer(input string tag, input int injectAt);
    int t = 0;
    int prevT = 0;
    int k = 0;
    logic prevS;
    @(negedge clk);
    startP = 1'b1;
    @(negedge clk);
    startP = 1'b0;
    // R2
    chk(busy === 1'b1, "R2", "busy after start", busy, 1);
    prevS = cpol;
    while (k < 32 && t < 100000) begin
      @(negedge clk);
      t++;
      startP = (t == injectAt);
      if (sclk !== prevS) begin
        chk((t - prevT) == expLen(k), tag, $sformatf("half %0d length", k), t - prevT, expLen(k));
        // R8
        if (sclk === 1'b1)
          chk(riseStb === 1'b1 && fallStb === 1'b0, "R8", "rise strobe", {riseStb, fallStb}, 2);
        else
          chk(fallStb === 1'b1 && riseStb === 1'b0, "R8", "fall strobe", {riseStb, fallStb}, 1);
        // R7
        chk(doneP === (k == 31), "R7", $sformatf("done at edge %0d", k), doneP, (k == 31));
        prevS = sclk;
        prevT = t;
        k++;
      end
    end
    startP = 1'b0;
    chk(k == 32, "R7", "edge count", k, 32);
    chk(busy === 1'b0, "R7", "busy low at final edge", busy, 0);
    @(negedge clk);
    // R1 R7 R9: no further word, idle level, single-cycle done
    chk(busy === 1'b0, "R9", "no restart after final edge", busy, 0);
    chk(doneP === 1'b0, "R7", "done one cycle", doneP, 0);
    chk(sclk === cpol, "R1", "idle level", sclk, cpol);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(sclk === 1'b0, "R1", "reset sclk", sclk, 0);
    chk(busy === 1'b0, "R1", "reset busy", busy, 0);
    chk({riseStb, fallStb, doneP} === 3'b000, "R1", "reset strobes", {riseStb, fallStb, doneP}, 0);
    cpol = 1'b1;
    @(negedge clk);
    chk(sclk === 1'b1, "R1", "idle follows cpol", sclk, 1);
    cpol = 1'b0;
  endtask

  task automatic testFixed();
    // R4: divB and pattern must not matter
    varEn = 0; bypassEn = 0; reorderEn = 0; cpol = 0;
    divA = 16'd2; divB = 16'd7; pattern = 32'hA5A5_F00F;
    runXfer("R4", 0);
  endtask

  task automatic testVariable();
    // R3
    varEn = 1; cpol = 0; divA = 16'd1; divB = 16'd4; pattern = 32'hC3A5_0F96;
    runXfer("R3", 0);
  endtask

  task automatic testPolarity();
    // R8 R3 with idle-high clock
    varEn = 1; cpol = 1; divA = 16'd0; divB = 16'd2; pattern = 32'h8000_0001;
    runXfer("R8", 0);
  endtask

  task automatic testRestart();
    // R10: same pattern twice, index must restart at bit 31
    varEn = 1; cpol = 0; divA = 16'd3; divB = 16'd0; pattern = 32'h0000_FFFF;
    runXfer("R10", 0);
    runXfer("R10", 0);
  endtask

  task automatic testBypass();
    // R5
    varEn = 0; reorderEn = 0; bypassEn = 1; cpol = 0; divA = 16'd5; divB = 16'd9;
    runXfer("R5", 0);
  endtask

  task automatic testBypassBlocked();
    // R6
    bypassEn = 1; varEn = 1; reorderEn = 0; divA = 16'd1; divB = 16'd3; pattern = 32'h0F0F_3355;
    runXfer("R6", 0);
    varEn = 0; reorderEn = 1; divA = 16'd2;
    runXfer("R6", 0);
    bypassEn = 0; reorderEn = 0;
  endtask

  task automatic testStartBusy();
    int totalLen = 0;
    // R9 mid-word start
    varEn = 1; cpol = 0; divA = 16'd2; divB = 16'd1; pattern = 32'h6996_1248;
    runXfer("R9", 5);
    // R9 start in the cycle of the final edge
    for (int k = 0; k < 32; k++) totalLen += expLen(k);
    runXfer("R9", totalLen - 1);
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testFixed();
    testVariable();
    testPolarity();
    testRestart();
    testBypass();
    testBypassBlocked();
    testStartBusy();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule